// File: doc/BRIEF.md
# Voice Packet Assembler and Destination Filter

This block sits between the sample buffers of a voice station and its byte-serial link to a shared bus. On the send side it waits until the outgoing sample buffer holds enough bytes for a whole frame. It then pops four samples and places a one-byte header in front of them, built from the station's configuration inputs. The five bytes go to the serial transmitter one at a time over a valid/ready stream. If the transmitter reports that it lost the bus, the block sends the whole frame again from the header, using the four samples it still holds.

On the receive side every station hears every frame, so the filtering is done here. Bytes from the serial receiver are gathered into a header and four samples. The header is decoded after the last sample. The samples go out one at a time on the playback stream only when the frame names this station as destination and some other station as source. A long silence in the middle of a frame throws the partial frame away, and the next byte is taken as a new header.

Top module: `voice_pkt_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, srcReady, txValid and playValid are low and rxReady is high.
- R2: A frame is started only in a cycle when srcLevel is at least 4. While srcLevel stays below 4, srcReady stays low and no byte is offered to the transmitter.
- R3: Once started, the block accepts exactly four samples on the src stream (srcReady high, one per srcValid). It then offers five bytes on the tx stream: the header first, then the four samples in the order they were popped. Each byte leaves on a cycle with txValid and txReady high and txCollide low.
- R4: The header byte is {cfgCtrl, cfgDest, cfgStation}: control in bits 7:6, destination in bits 5:3 and own address (source) in bits 2:0. It is sampled in the cycle the frame is started.
- R5: While txValid is high and txReady is low, txData holds its value and txValid stays high, unless txCollide is high.
- R6: A cycle with txValid and txCollide high restarts the frame. The next byte offered is the header again, followed by the same four samples. txCollide has priority over txReady in that cycle, and no byte counts as sent.
- R7: A received frame is forwarded when its destination (bits 5:3 of the first byte) equals cfgStation and its source (bits 2:0) differs from it. Its four samples then appear on playData in arrival order. rxReady stays low from the cycle after the last sample until the fourth sample has been accepted on the play stream.
- R8: A received frame whose destination differs from cfgStation produces no playValid.
- R9: A received frame whose source equals cfgStation produces no playValid, even if its destination matches.
- R10: If GAP_LIMIT consecutive cycles pass without a byte while a frame is partly received, the partial frame is dropped. The next byte is treated as a header.
- R11: A gap of GAP_LIMIT-1 idle cycles between bytes of a frame does not break it.
- R12: While playValid is high and playReady is low, playData holds and playValid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgCtrl | input | 2 | Control bits placed in outgoing headers |
| cfgDest | input | 3 | Destination address for outgoing frames |
| cfgStation | input | 3 | This station's own address |
| srcLevel | input | LEVEL_W | Number of samples waiting in the outgoing buffer |
| srcValid | input | 1 | Outgoing sample byte valid |
| srcData | input | 8 | Outgoing sample byte |
| srcReady | output | 1 | Block pops a sample this cycle when srcValid is high |
| txValid | output | 1 | Byte offered to the serial transmitter |
| txData | output | 8 | Byte to transmit |
| txReady | input | 1 | Transmitter takes the byte |
| txCollide | input | 1 | Transmitter lost arbitration; restart the frame |
| rxValid | input | 1 | Byte from the serial receiver valid |
| rxData | input | 8 | Received byte |
| rxReady | output | 1 | Block can take a received byte |
| playValid | output | 1 | Sample offered to the playback buffer |
| playData | output | 8 | Sample for playback |
| playReady | input | 1 | Playback buffer takes the sample |

## Verification
The bench goes after a collision that arrives in the same cycle as txReady. A design that let the handshake win would skip the header on the retry and send a broken frame. It also checks frames addressed to another station and frames carrying the station's own source address; a filter that compared the wrong field would play back foreign or looped-back audio. The receive gap is probed at exactly GAP_LIMIT and at GAP_LIMIT-1 idle cycles. An off-by-one timer would either tear a slow but valid frame apart or glue a fresh header onto a stale half-frame, which shifts every later sample. Stalls on txReady and playReady show that a design which moved on without the handshake drops or repeats bytes.

// File: rtl/vpe_pkg.sv
`timescale 1ns/1ps
package vpe_pkg;
  localparam int PKT_SAMPLES = 4;
  localparam int IDX_W       = 3;
  localparam int CTRL_W      = 2;
  localparam int ADDR_W      = 3;

  typedef enum logic [1:0] {TX_IDLE, TX_LOAD, TX_SEND} tx_state_e;

  typedef struct packed {
    logic             txHdrCap;
    logic             txSmpWe;
    logic [IDX_W-1:0] txWrIdx;
    logic [IDX_W-1:0] txRdSel;   // 0 selects header, k selects sample k-1
    logic             rxHdrWe;
    logic             rxSmpWe;
    logic [IDX_W-1:0] rxWrIdx;
    logic [IDX_W-1:0] playSel;
  } vpe_strobe_t;
endpackage

// File: rtl/vpe_datapath.sv
`timescale 1ns/1ps
module vpe_datapath
  import vpe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  vpe_strobe_t       st,
  input  logic [CTRL_W-1:0] cfgCtrl,
  input  logic [ADDR_W-1:0] cfgDest,
  input  logic [ADDR_W-1:0] cfgStation,
  input  logic [7:0]        srcData,
  input  logic [7:0]        rxData,
  output logic [7:0]        txData,
  output logic [7:0]        playData,
  output logic [ADDR_W-1:0] rxDestField,
  output logic [ADDR_W-1:0] rxSrcField
);
  logic [7:0] txHdr;
  logic [7:0] txSmp [PKT_SAMPLES];
  logic [2*ADDR_W-1:0] rxRoute;
  logic [7:0] rxSmp [PKT_SAMPLES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHdr   <= '0;
      rxRoute <= '0;
    end else begin
      if (st.txHdrCap) txHdr <= {cfgCtrl, cfgDest, cfgStation};
      if (st.rxHdrWe)  rxRoute <= rxData[2*ADDR_W-1:0];
    end
  end

  for (genvar g = 0; g < PKT_SAMPLES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        txSmp[g] <= '0;
        rxSmp[g] <= '0;
      end else begin
        if (st.txSmpWe && st.txWrIdx == IDX_W'(g)) txSmp[g] <= srcData;
        if (st.rxSmpWe && st.rxWrIdx == IDX_W'(g)) rxSmp[g] <= rxData;
      end
    end
  end

  always_comb begin
    txData = txHdr;
    for (int k = 0; k < PKT_SAMPLES; k++)
      if (st.txRdSel == IDX_W'(k + 1)) txData = txSmp[k];
  end

  always_comb begin
    playData = rxSmp[0];
    for (int k = 1; k < PKT_SAMPLES; k++)
      if (st.playSel == IDX_W'(k)) playData = rxSmp[k];
  end

  assign rxDestField = rxRoute[2*ADDR_W-1:ADDR_W];
  assign rxSrcField  = rxRoute[ADDR_W-1:0];
endmodule

// File: rtl/vpe_ctrl.sv
`timescale 1ns/1ps
module vpe_ctrl
  import vpe_pkg::*;
#(
  parameter int GAP_LIMIT = 16,
  parameter int LEVEL_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] srcLevel,
  input  logic               srcValid,
  input  logic               txReady,
  input  logic               txCollide,
  input  logic               rxValid,
  input  logic               playReady,
  input  logic [ADDR_W-1:0]  rxDestField,
  input  logic [ADDR_W-1:0]  rxSrcField,
  input  logic [ADDR_W-1:0]  cfgStation,
  output logic               srcReady,
  output logic               txValid,
  output logic               rxReady,
  output logic               playValid,
  output vpe_strobe_t        st
);
  localparam int GAP_W = $clog2(GAP_LIMIT + 1);

  tx_state_e        txState, txStateNxt;
  logic [IDX_W-1:0] txIdx, txIdxNxt;
  logic [IDX_W-1:0] rxIdx, rxIdxNxt;
  logic [GAP_W-1:0] gapCnt, gapCntNxt;
  logic             fwdOn, fwdOnNxt;
  logic [IDX_W-1:0] playIdx, playIdxNxt;
  logic             rxTake, frameOk;

  // transmit sequencing
  always_comb begin
    txStateNxt  = txState;
    txIdxNxt    = txIdx;
    srcReady    = 1'b0;
    txValid     = 1'b0;
    st.txHdrCap = 1'b0;
    st.txSmpWe  = 1'b0;
    st.txWrIdx  = txIdx;
    st.txRdSel  = txIdx;
    unique case (txState)
      TX_IDLE: begin
        if (srcLevel >= LEVEL_W'(PKT_SAMPLES)) begin
          st.txHdrCap = 1'b1;
          txStateNxt  = TX_LOAD;
          txIdxNxt    = '0;
        end
      end
      TX_LOAD: begin
        srcReady   = 1'b1;
        st.txSmpWe = srcValid;
        if (srcValid) begin
          if (txIdx == IDX_W'(PKT_SAMPLES - 1)) begin
            txStateNxt = TX_SEND;
            txIdxNxt   = '0;
          end else begin
            txIdxNxt = txIdx + 1'b1;
          end
        end
      end
      TX_SEND: begin
        txValid = 1'b1;
        if (txCollide) begin
          txIdxNxt = '0;
        end else if (txReady) begin
          if (txIdx == IDX_W'(PKT_SAMPLES)) begin
            txStateNxt = TX_IDLE;
            txIdxNxt   = '0;
          end else begin
            txIdxNxt = txIdx + 1'b1;
          end
        end
      end
      default: begin
        txStateNxt = TX_IDLE;
        txIdxNxt   = '0;
      end
    endcase
  end

  // receive collection, filtering and forwarding
  assign rxReady   = !fwdOn;
  assign playValid = fwdOn;
  assign rxTake    = rxValid && !fwdOn;
  assign frameOk   = (rxDestField == cfgStation) && (rxSrcField != cfgStation);

  always_comb begin
    rxIdxNxt   = rxIdx;
    gapCntNxt  = gapCnt;
    fwdOnNxt   = fwdOn;
    playIdxNxt = playIdx;
    st.rxHdrWe = 1'b0;
    st.rxSmpWe = 1'b0;
    st.rxWrIdx = rxIdx - 1'b1;
    st.playSel = playIdx;
    if (fwdOn) begin
      if (playReady) begin
        if (playIdx == IDX_W'(PKT_SAMPLES - 1)) begin
          fwdOnNxt   = 1'b0;
          playIdxNxt = '0;
        end else begin
          playIdxNxt = playIdx + 1'b1;
        end
      end
    end else if (rxTake) begin
      gapCntNxt = '0;
      if (rxIdx == '0) begin
        st.rxHdrWe = 1'b1;
        rxIdxNxt   = IDX_W'(1);
      end else begin
        st.rxSmpWe = 1'b1;
        if (rxIdx == IDX_W'(PKT_SAMPLES)) begin
          rxIdxNxt = '0;
          fwdOnNxt = frameOk;
        end else begin
          rxIdxNxt = rxIdx + 1'b1;
        end
      end
    end else if (rxIdx != '0) begin
      if (gapCnt == GAP_W'(GAP_LIMIT - 1)) begin
        rxIdxNxt  = '0;
        gapCntNxt = '0;
      end else begin
        gapCntNxt = gapCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txIdx   <= '0;
      rxIdx   <= '0;
      gapCnt  <= '0;
      fwdOn   <= 1'b0;
      playIdx <= '0;
    end else begin
      txState <= txStateNxt;
      txIdx   <= txIdxNxt;
      rxIdx   <= rxIdxNxt;
      gapCnt  <= gapCntNxt;
      fwdOn   <= fwdOnNxt;
      playIdx <= playIdxNxt;
    end
  end
endmodule

// File: rtl/voice_pkt_engine.sv
`timescale 1ns/1ps
module voice_pkt_engine
  import vpe_pkg::*;
#(
  parameter int GAP_LIMIT = 16,
  parameter int LEVEL_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         cfgCtrl,
  input  logic [2:0]         cfgDest,
  input  logic [2:0]         cfgStation,
  input  logic [LEVEL_W-1:0] srcLevel,
  input  logic               srcValid,
  input  logic [7:0]         srcData,
  output logic               srcReady,
  output logic               txValid,
  output logic [7:0]         txData,
  input  logic               txReady,
  input  logic               txCollide,
  input  logic               rxValid,
  input  logic [7:0]         rxData,
  output logic               rxReady,
  output logic               playValid,
  output logic [7:0]         playData,
  input  logic               playReady
);
  vpe_strobe_t       st;
  logic [ADDR_W-1:0] rxDestField;
  logic [ADDR_W-1:0] rxSrcField;

  vpe_ctrl #(.GAP_LIMIT(GAP_LIMIT), .LEVEL_W(LEVEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .srcValid(srcValid),
    .txReady(txReady), .txCollide(txCollide), .rxValid(rxValid),
    .playReady(playReady), .rxDestField(rxDestField), .rxSrcField(rxSrcField),
    .cfgStation(cfgStation), .srcReady(srcReady), .txValid(txValid),
    .rxReady(rxReady), .playValid(playValid), .st(st)
  );

  vpe_datapath u_dp (
    .clk(clk), .rstN(rstN), .st(st), .cfgCtrl(cfgCtrl), .cfgDest(cfgDest),
    .cfgStation(cfgStation), .srcData(srcData), .rxData(rxData),
    .txData(txData), .playData(playData), .rxDestField(rxDestField),
    .rxSrcField(rxSrcField)
  );
endmodule

// File: rtl/vpe_chk.sv
`timescale 1ns/1ps
module vpe_chk #(
  parameter int LEVEL_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [LEVEL_W-1:0] srcLevel,
  input logic               srcReady,
  input logic               txValid,
  input logic [7:0]         txData,
  input logic               txReady,
  input logic               txCollide,
  input logic               rxReady,
  input logic               playValid,
  input logic [7:0]         playData,
  input logic               playReady
);
  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(srcReady) |-> $past(srcLevel) >= LEVEL_W'(4));

  // R3
  pop_send_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(srcReady && txValid));

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady && !txCollide |=> txValid && $stable(txData));

  // R6
  collide_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txCollide |=> txValid);

  // R7
  rx_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    playValid |-> !rxReady);

  // R12
  play_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    playValid && !playReady |=> playValid && $stable(playData));
endmodule

bind voice_pkt_engine vpe_chk #(.LEVEL_W(LEVEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .srcReady(srcReady),
  .txValid(txValid), .txData(txData), .txReady(txReady), .txCollide(txCollide),
  .rxReady(rxReady), .playValid(playValid), .playData(playData),
  .playReady(playReady)
);

// File: tb/sim_voice_pkt_engine.sv
`timescale 1ns/1ps
module sim_voice_pkt_engine;
  localparam int GAP = 16;
  localparam int LW  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cfgCtrl = 2'b10;
  logic [2:0] cfgDest = 3'd5;
  logic [2:0] cfgStation = 3'd3;
  logic [LW-1:0] srcLevel = '0;
  logic srcValid = 1'b0;
  logic [7:0] srcData = '0;
  logic srcReady, txValid, rxReady, playValid;
  logic [7:0] txData, playData;
  logic txReady = 1'b0, txCollide = 1'b0;
  logic rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic playReady = 1'b1;

  int nChk = 0, nFail = 0;
  bit running = 1'b0;
  logic [7:0] gotTx[$];
  logic [7:0] gotPlay[$];

  always #2.5 clk = ~clk;

  voice_pkt_engine #(.GAP_LIMIT(GAP), .LEVEL_W(LW)) u0 (
    .clk(clk), .rstN(rstN), .cfgCtrl(cfgCtrl), .cfgDest(cfgDest),
    .cfgStation(cfgStation), .srcLevel(srcLevel), .srcValid(srcValid),
    .srcData(srcData), .srcReady(srcReady), .txValid(txValid), .txData(txData),
    .txReady(txReady), .txCollide(txCollide), .rxValid(rxValid), .rxData(rxData),
    .rxReady(rxReady), .playValid(playValid), .playData(playData),
    .playReady(playReady)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference, updated on each rising edge
  int mT = 0, mTi = 0, mR = 0, mGap = 0, mP = 0;
  bit mF = 1'b0;
  logic [7:0] mHdr = '0, mRh = '0;
  logic [7:0] mTs[4];
  logic [7:0] mRs[4];

  always @(posedge clk) begin
    if (!rstN) begin
      mT = 0; mTi = 0; mR = 0; mGap = 0; mP = 0; mF = 1'b0;
    end else begin
      if (txValid && txReady && !txCollide) gotTx.push_back(txData);
      if (playValid && playReady) gotPlay.push_back(playData);
      if (mT == 0) begin
        if (srcLevel >= 4) begin mT = 1; mTi = 0; mHdr = {cfgCtrl, cfgDest, cfgStation}; end
      end else if (mT == 1) begin
        if (srcValid) begin
          mTs[mTi] = srcData;
          if (mTi == 3) begin mT = 2; mTi = 0; end else mTi++;
        end
      end else begin
        if (txCollide) mTi = 0;
        else if (txReady) begin
          if (mTi == 4) begin mT = 0; mTi = 0; end else mTi++;
        end
      end
      if (mF) begin
        if (playReady) begin
          if (mP == 3) begin mF = 1'b0; mP = 0; end else mP++;
        end
      end else if (rxValid) begin
        mGap = 0;
        if (mR == 0) begin mRh = rxData; mR = 1; end
        else begin
          mRs[mR-1] = rxData;
          if (mR == 4) begin
            mR = 0;
            mF = (mRh[5:3] == cfgStation) && (mRh[2:0] != cfgStation);
          end else mR++;
        end
      end else if (mR != 0) begin
        if (mGap == GAP - 1) begin mR = 0; mGap = 0; end else mGap++;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (running) begin
      chk(srcReady == (mT == 1), "R3 srcReady", srcReady, mT == 1);
      chk(txValid == (mT == 2), "R3 txValid", txValid, mT == 2);
      if (mT == 2) chk(txData == ((mTi == 0) ? mHdr : mTs[mTi-1]), "R3 txData",
                       txData, (mTi == 0) ? mHdr : mTs[mTi-1]);
      chk(rxReady == !mF, "R7 rxReady", rxReady, !mF);
      chk(playValid == mF, "R7 playValid", playValid, mF);
      if (mF) chk(playData == mRs[mP], "R7 playData", playData, mRs[mP]);
    end
  end

  task automatic push_samples(input logic [7:0] b[4]);
    for (int i = 0; i < 4; i++) begin
      srcData = b[i];
      srcValid = 1'b1;
      while (!srcReady) @(negedge clk);
      @(negedge clk);
      srcValid = 1'b0;
      if (i == 1) @(negedge clk);
    end
    srcLevel = '0;
  endtask

  task automatic drain_tx(input int total, input bit stall, input int collAt);
    int cyc = 0;
    bit done = 1'b0;
    int base = gotTx.size();
    while (gotTx.size() < base + total) begin
      @(negedge clk);
      cyc++;
      txReady = stall ? (cyc % 3 != 0) : 1'b1;
      txCollide = (!done && collAt >= 0 && txValid && gotTx.size() == base + collAt);
      if (txCollide) done = 1'b1;
    end
    txReady = 1'b0;
    txCollide = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] b);
    while (!rxReady) @(negedge clk);
    rxData = b;
    rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic rx_frame(input logic [7:0] h, input logic [7:0] b[4]);
    rx_byte(h);
    for (int i = 0; i < 4; i++) rx_byte(b[i]);
    repeat (2) @(negedge clk);
    while (playValid) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] sa[4];
    logic [7:0] sb[4];
    logic [7:0] ra[4];
    int n;
    sa = '{8'hA1, 8'hA2, 8'hA3, 8'hA4};
    sb = '{8'h51, 8'h52, 8'h53, 8'h54};
    ra = '{8'h11, 8'h22, 8'h33, 8'h44};
    repeat (3) @(negedge clk);
    // R1 reset values while in reset
    chk({srcReady, txValid, playValid, rxReady} == 4'b0001, "R1", {srcReady, txValid, playValid, rxReady}, 4'b0001);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);
    chk({srcReady, txValid, playValid, rxReady} == 4'b0001, "R1", {srcReady, txValid, playValid, rxReady}, 4'b0001);

    // R2 three samples are not enough
    srcLevel = 8'd3;
    repeat (10) @(negedge clk);
    chk(srcReady == 1'b0 && txValid == 1'b0, "R2", {srcReady, txValid}, 0);

    // R3 R4 R5 plain frame with transmitter stalls; header 10_101_011 = AB
    srcLevel = 8'd6;
    fork
      push_samples(sa);
      drain_tx(5, 1'b1, -1);
    join
    chk(gotTx.size() == 5, "R3 count", gotTx.size(), 5);
    chk(gotTx[0] == 8'hAB, "R4 header", gotTx[0], 8'hAB);
    for (int i = 0; i < 4; i++) chk(gotTx[i+1] == sa[i], "R3 order", gotTx[i+1], sa[i]);
    repeat (4) @(negedge clk);
    chk(txValid == 1'b0, "R2 idle after frame", txValid, 0);

    // R6 collision after header and one sample, new config 01_110_011 = 73
    cfgCtrl = 2'b01; cfgDest = 3'd6;
    gotTx.delete();
    srcLevel = 8'd4;
    fork
      push_samples(sb);
      drain_tx(7, 1'b0, 2);
    join
    chk(gotTx.size() == 7, "R6 count", gotTx.size(), 7);
    chk(gotTx[2] == 8'h73, "R6 header resent", gotTx[2], 8'h73);
    for (int i = 0; i < 4; i++) chk(gotTx[i+3] == sb[i], "R6 samples kept", gotTx[i+3], sb[i]);

    // R7 R12 frame for this station (01_011_101 = 5D), playback stalled
    playReady = 1'b0;
    rx_byte(8'h5D);
    for (int i = 0; i < 4; i++) rx_byte(ra[i]);
    repeat (5) @(negedge clk);
    chk(playValid == 1'b1 && playData == 8'h11, "R12 held", playData, 8'h11);
    chk(rxReady == 1'b0, "R7 blocked", rxReady, 0);
    playReady = 1'b1;
    while (playValid) @(negedge clk);
    chk(gotPlay.size() == 4, "R7 count", gotPlay.size(), 4);
    for (int i = 0; i < 4; i++) chk(gotPlay[i] == ra[i], "R7 order", gotPlay[i], ra[i]);

    // R8 other destination (00_010_101 = 15)
    n = gotPlay.size();
    rx_frame(8'h15, ra);
    chk(gotPlay.size() == n, "R8", gotPlay.size(), n);

    // R9 own source (00_011_011 = 1B)
    rx_frame(8'h1B, ra);
    chk(gotPlay.size() == n, "R9", gotPlay.size(), n);

    // R10 partial frame, full gap, then a complete frame
    rx_byte(8'h15);
    rx_byte(8'h99);
    repeat (GAP) @(negedge clk);
    rx_frame(8'h5D, sb);
    chk(gotPlay.size() == n + 4, "R10 resync", gotPlay.size(), n + 4);
    if (gotPlay.size() == n + 4) chk(gotPlay[n] == 8'h51, "R10 data", gotPlay[n], 8'h51);

    // R11 gap one short of the limit keeps the frame
    n = gotPlay.size();
    rx_byte(8'h5D);
    rx_byte(8'hC1);
    repeat (GAP - 1) @(negedge clk);
    rx_byte(8'hC2);
    rx_byte(8'hC3);
    rx_byte(8'hC4);
    repeat (2) @(negedge clk);
    while (playValid) @(negedge clk);
    chk(gotPlay.size() == n + 4, "R11 kept", gotPlay.size(), n + 4);
    if (gotPlay.size() == n + 4) chk(gotPlay[n+1] == 8'hC2, "R11 data", gotPlay[n+1], 8'hC2);

    repeat (3) @(negedge clk);
    running = 1'b0;
    finish_run();
  end
endmodule